// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between an asynchronous-style byte-wide memory bus and the write state machine of a boot-block flash device. Bus writes are byte commands. Each accepted command sets which source later reads return: the memory array, the status byte or the identifier codes. Commands can also start a two-write program sequence, clear the sticky error bits, or suspend and resume an erase that the state machine is running. All bus pins are sampled on the system clock. The bench or the surrounding logic keeps them clean on that clock.

The controller owns the status byte. The byte presented on the bus is a snapshot. It is taken when the second of the two enables (chip enable, output enable) goes low, and it stays frozen until an enable is released and lowered again. Error flags raised by the state machine stay set until software writes the clear command.

The command state machine has five states:
- ST_ARRAY: array reads.
- ST_STATUS: status reads.
- ST_IDENT: identifier reads.
- ST_PSETUP: the program command was seen and the next write is taken as address and data.
- ST_PBUSY: a program operation is in flight.

Its transitions are:
- A decoded command moves between the three read states, or into ST_PSETUP on 40h.
- Any write in ST_PSETUP moves to ST_PBUSY and issues the start pulse.
- The done pulse in ST_PBUSY moves to ST_STATUS.
- The clear command and an ineffective resume keep the current state.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode, no request pulse is active, and the status byte reads 80h (ready, no flags).
- R2: A write of FFh, or of any code other than 70h, 50h, 40h, 90h, B0h and D0h, selects array reads. The output then equals `arr_rdata`.
- R3: A write of 70h selects status reads, and every later read returns the status byte until a different command is written.
- R4: A write of 90h selects identifier reads. Address bit 0 = 0 returns MFR_CODE and address bit 0 = 1 returns DEV_CODE.
- R5: A write of 40h followed by any second write produces exactly one `wsm_start` pulse carrying that second write's address and data. The 40h write itself starts nothing.
- R6: While a program operation runs, status bit 7 reads 0 and all reads return status. Every command except 70h, including FFh and 50h, is ignored.
- R7: When `wsm_done` ends a program operation, reads keep returning status (bit 7 = 1). Array reads return only after an FFh command.
- R8: Status bits 5 (erase fail), 4 (program fail) and 3 (supply fault) are set by `wsm_erase_fail`, `wsm_prog_fail` and `wsm_vpp_err`. They stay set until a 50h command clears them. Bits 2 to 0 always read 0.
- R9: The status byte seen on the bus is captured on the clock in which both enables are first low. It does not change while they stay low, even if the flags change.
- R10: B0h while `wsm_erasing` is high and no suspend is pending issues one `wsm_suspend` pulse, sets status bit 6 and selects status reads. Otherwise B0h issues no pulse but still selects status reads.
- R11: D0h with a suspend pending issues one `wsm_resume` pulse, clears bit 6 and selects status reads. With no suspend pending it issues no pulse and leaves the read mode unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data |
| arr_rdata | input | 8 | Data read from the array at `addr` |
| wsm_start | output | 1 | Program start request (one cycle) |
| wsm_addr | output | ADDR_W | Program target address |
| wsm_data | output | 8 | Program data |
| wsm_suspend | output | 1 | Erase suspend request (one cycle) |
| wsm_resume | output | 1 | Erase resume request (one cycle) |
| wsm_busy | input | 1 | State machine is running |
| wsm_done | input | 1 | Program operation finished (one cycle) |
| wsm_erasing | input | 1 | An erase is in progress |
| wsm_vpp_err | input | 1 | Supply out of range, sets bit 3 |
| wsm_prog_fail | input | 1 | Program failure, sets bit 4 |
| wsm_erase_fail | input | 1 | Erase failure, sets bit 5 |

## Verification
A command takes effect at the first rising clock edge after the write strobe ends. The request pulses it causes are high only in the half cycle before that edge, so the bench reads them one time unit after it releases the strobe. A status snapshot is taken at the rising edge where both enables are first seen low, so the bench reads `dout` at the following falling edge. Array and identifier reads are combinational and are sampled in that same slot. Flag pulses from the bench are driven on falling edges, so each one lands in the sticky bits at the next rising edge, before any read that expects it.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DQ_W = 8;

    localparam logic [DQ_W-1:0] OP_READ_ARRAY = 8'hFF;
    localparam logic [DQ_W-1:0] OP_READ_STAT  = 8'h70;
    localparam logic [DQ_W-1:0] OP_CLR_STAT   = 8'h50;
    localparam logic [DQ_W-1:0] OP_PROGRAM    = 8'h40;
    localparam logic [DQ_W-1:0] OP_READ_ID    = 8'h90;
    localparam logic [DQ_W-1:0] OP_SUSPEND    = 8'hB0;
    localparam logic [DQ_W-1:0] OP_RESUME     = 8'hD0;

    typedef enum logic [2:0] {
        ST_ARRAY,
        ST_STATUS,
        ST_IDENT,
        ST_PSETUP,
        ST_PBUSY
    } cmd_state_e;

    typedef enum logic [1:0] {
        SRC_ARRAY,
        SRC_STATUS,
        SRC_IDENT
    } rd_src_e;
endpackage

// File: rtl/fcc_bus_sense.sv
module fcc_bus_sense #(
    parameter int ADDR_W = 18,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic              rd_act,
    output logic              rd_act_q,
    output logic              rd_start
);
    timeunit 1ns;
    timeprecision 1ps;

    logic wr_act;
    logic wr_act_q;

    assign wr_act = !ce_n && !we_n;
    assign rd_act = !ce_n && !oe_n;

    // A write is committed when the strobe is released; the read snapshot
    // fires when the later of the two enables has gone low.
    assign wr_commit = wr_act_q && !wr_act;
    assign rd_start  = rd_act && !rd_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_act_q <= 1'b0;
            rd_act_q <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_act_q <= wr_act;
            rd_act_q <= rd_act;
            if (wr_act) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end
endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
    import fcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_commit,
    input  logic [DQ_W-1:0] wr_data,
    input  logic            wsm_done,
    input  logic            wsm_erasing,
    input  logic            susp_flag,
    output rd_src_e         rd_src,
    output logic            prog_active,
    output logic            start_req,
    output logic            susp_req,
    output logic            resume_req,
    output logic            clr_req
);
    timeunit 1ns;
    timeprecision 1ps;

    cmd_state_e state_q;
    cmd_state_e state_d;
    logic       cmd_slot;

    function automatic cmd_state_e decode_op(input logic [DQ_W-1:0] op,
                                             input cmd_state_e       cur,
                                             input logic             susp);
        cmd_state_e nxt;
        case (op)
            OP_READ_ARRAY: nxt = ST_ARRAY;
            OP_READ_STAT:  nxt = ST_STATUS;
            OP_READ_ID:    nxt = ST_IDENT;
            OP_PROGRAM:    nxt = ST_PSETUP;
            OP_CLR_STAT:   nxt = cur;
            OP_SUSPEND:    nxt = ST_STATUS;
            OP_RESUME:     nxt = susp ? ST_STATUS : cur;
            default:       nxt = ST_ARRAY;
        endcase
        return nxt;
    endfunction

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARRAY;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARRAY, ST_STATUS, ST_IDENT: begin
                if (wr_commit) state_d = decode_op(wr_data, state_q, susp_flag);
            end
            ST_PSETUP: begin
                if (wr_commit) state_d = ST_PBUSY;
            end
            ST_PBUSY: begin
                if (wsm_done) state_d = ST_STATUS;
            end
            default: state_d = ST_ARRAY;
        endcase
    end

    // Output logic
    always_comb begin
        cmd_slot    = wr_commit && (state_q == ST_ARRAY || state_q == ST_STATUS ||
                                    state_q == ST_IDENT);
        start_req   = wr_commit && (state_q == ST_PSETUP);
        susp_req    = cmd_slot && (wr_data == OP_SUSPEND) && wsm_erasing && !susp_flag;
        resume_req  = cmd_slot && (wr_data == OP_RESUME) && susp_flag;
        clr_req     = cmd_slot && (wr_data == OP_CLR_STAT);
        prog_active = (state_q == ST_PBUSY);
        unique case (state_q)
            ST_ARRAY: rd_src = SRC_ARRAY;
            ST_IDENT: rd_src = SRC_IDENT;
            default:  rd_src = SRC_STATUS;
        endcase
    end

    // R5
    start_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |=> (state_q == ST_PBUSY));

    // R5
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, susp_req, resume_req, clr_req}));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PBUSY && !wsm_done) |=> (state_q == ST_PBUSY));

    // R7
    done_to_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PBUSY && wsm_done) |=> (state_q == ST_STATUS));
endmodule

// File: rtl/fcc_status_reg.sv
module fcc_status_reg
    import fcc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wsm_busy,
    input  logic            prog_active,
    input  logic            wsm_vpp_err,
    input  logic            wsm_prog_fail,
    input  logic            wsm_erase_fail,
    input  logic            clr_req,
    input  logic            susp_req,
    input  logic            resume_req,
    input  logic            rd_act,
    input  logic            rd_act_q,
    input  logic            rd_start,
    output logic            susp_flag,
    output logic [DQ_W-1:0] snap
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0]      sticky_q;
    logic [2:0]      sticky_set;
    logic [DQ_W-1:0] live;
    logic            ready;

    assign sticky_set = {wsm_erase_fail, wsm_prog_fail, wsm_vpp_err};
    assign ready      = !wsm_busy && !prog_active;
    assign live       = {ready, susp_flag, sticky_q, 3'b000};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sticky_q  <= '0;
            susp_flag <= 1'b0;
            snap      <= 8'h80;
        end else begin
            sticky_q <= (clr_req ? 3'b000 : sticky_q) | sticky_set;
            if (susp_req)        susp_flag <= 1'b1;
            else if (resume_req) susp_flag <= 1'b0;
            if (rd_start) snap <= live;
        end
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_act_q) |=> $stable(snap));

    // R10
    suspend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        susp_req |=> susp_flag);

    // R11
    resume_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_req |=> !susp_flag);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int              ADDR_W   = 18,
    parameter logic [DQ_W-1:0] MFR_CODE = 8'hA5,
    parameter logic [DQ_W-1:0] DEV_CODE = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   din,
    output logic [DQ_W-1:0]   dout,
    input  logic [DQ_W-1:0]   arr_rdata,
    output logic              wsm_start,
    output logic [ADDR_W-1:0] wsm_addr,
    output logic [DQ_W-1:0]   wsm_data,
    output logic              wsm_suspend,
    output logic              wsm_resume,
    input  logic              wsm_busy,
    input  logic              wsm_done,
    input  logic              wsm_erasing,
    input  logic              wsm_vpp_err,
    input  logic              wsm_prog_fail,
    input  logic              wsm_erase_fail
);
    timeunit 1ns;
    timeprecision 1ps;

    logic            wr_commit;
    logic            rd_act;
    logic            rd_act_q;
    logic            rd_start;
    logic [DQ_W-1:0] wr_data;
    rd_src_e         rd_src;
    logic            prog_active;
    logic            clr_req;
    logic            susp_flag;
    logic [DQ_W-1:0] snap;

    fcc_bus_sense #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .din       (din),
        .wr_commit (wr_commit),
        .wr_addr   (wsm_addr),
        .wr_data   (wr_data),
        .rd_act    (rd_act),
        .rd_act_q  (rd_act_q),
        .rd_start  (rd_start)
    );

    fcc_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_commit   (wr_commit),
        .wr_data     (wr_data),
        .wsm_done    (wsm_done),
        .wsm_erasing (wsm_erasing),
        .susp_flag   (susp_flag),
        .rd_src      (rd_src),
        .prog_active (prog_active),
        .start_req   (wsm_start),
        .susp_req    (wsm_suspend),
        .resume_req  (wsm_resume),
        .clr_req     (clr_req)
    );

    fcc_status_reg u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .wsm_busy       (wsm_busy),
        .prog_active    (prog_active),
        .wsm_vpp_err    (wsm_vpp_err),
        .wsm_prog_fail  (wsm_prog_fail),
        .wsm_erase_fail (wsm_erase_fail),
        .clr_req        (clr_req),
        .susp_req       (wsm_suspend),
        .resume_req     (wsm_resume),
        .rd_act         (rd_act),
        .rd_act_q       (rd_act_q),
        .rd_start       (rd_start),
        .susp_flag      (susp_flag),
        .snap           (snap)
    );

    assign wsm_data = wr_data;

    always_comb begin
        unique case (rd_src)
            SRC_ARRAY: dout = arr_rdata;
            SRC_IDENT: dout = addr[0] ? DEV_CODE : MFR_CODE;
            default:   dout = snap;
        endcase
    end

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_active && rd_start) |=> !snap[7]);
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int         ADDR_W = 18;
    localparam logic [7:0] MFR    = 8'hA5;
    localparam logic [7:0] DEV    = 8'h3C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic [7:0]        arr_rdata;
    logic              wsm_start, wsm_suspend, wsm_resume;
    logic [ADDR_W-1:0] wsm_addr;
    logic [7:0]        wsm_data;
    logic              wsm_busy = 1'b0, wsm_done = 1'b0, wsm_erasing = 1'b0;
    logic              wsm_vpp_err = 1'b0, wsm_prog_fail = 1'b0, wsm_erase_fail = 1'b0;

    int errors = 0;
    int checks = 0;
    logic              last_start, last_susp, last_res;
    logic [ADDR_W-1:0] last_addr;
    logic [7:0]        last_data;
    logic [7:0]        rd;

    always #2.5 clk = ~clk;

    assign arr_rdata = addr[7:0] ^ 8'h5A;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .MFR_CODE(MFR), .DEV_CODE(DEV)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .arr_rdata(arr_rdata),
        .wsm_start(wsm_start), .wsm_addr(wsm_addr), .wsm_data(wsm_data),
        .wsm_suspend(wsm_suspend), .wsm_resume(wsm_resume),
        .wsm_busy(wsm_busy), .wsm_done(wsm_done), .wsm_erasing(wsm_erasing),
        .wsm_vpp_err(wsm_vpp_err), .wsm_prog_fail(wsm_prog_fail),
        .wsm_erase_fail(wsm_erase_fail)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called just after a falling clock edge; returns just after one.
    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
        @(posedge clk); @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        #1;
        last_start = wsm_start; last_susp = wsm_suspend; last_res = wsm_resume;
        last_addr = wsm_addr; last_data = wsm_data;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] q);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        q = dout;
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic pulse_flags(input logic [2:0] e);
        {wsm_erase_fail, wsm_prog_fail, wsm_vpp_err} = e;
        @(posedge clk); @(negedge clk);
        {wsm_erase_fail, wsm_prog_fail, wsm_vpp_err} = 3'b000;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 start", {31'd0, wsm_start}, 32'd0);
        bus_read(18'h10, rd);
        check("R1 array mode", rd, 32'h4A);
        bus_write(0, 8'h70);
        bus_read(18'h10, rd);
        check("R1 status", rd, 32'h80);

        // R2/R3/R4: sweep over every command code
        for (int c = 0; c < 256; c++) begin
            logic [7:0] exp;
            if (c == 8'h40 || c == 8'h50 || c == 8'hB0 || c == 8'hD0) continue;
            bus_write(0, 8'hFF);
            bus_write(0, c[7:0]);
            exp = (c == 8'h70) ? 8'h80 : (c == 8'h90) ? MFR : 8'h4A;
            bus_read(18'h10, rd);
            check("R2 R3 R4 first read", rd, exp);
            bus_read(18'h10, rd);
            check("R2 R3 R4 repeat read", rd, exp);
        end
        bus_write(0, 8'h90);
        bus_read(18'h11, rd);
        check("R4 device code", rd, DEV);

        // R8: every combination of error flags
        for (int e = 0; e < 8; e++) begin
            bus_write(0, 8'h50);
            bus_write(0, 8'h70);
            pulse_flags(e[2:0]);
            bus_read(0, rd);
            check("R8 flag set", rd, 32'h80 | (e << 3));
            bus_read(0, rd);
            check("R8 flag persists", rd, 32'h80 | (e << 3));
        end
        bus_write(0, 8'h50);
        bus_read(0, rd);
        check("R8 cleared", rd, 32'h80);

        // R5/R6/R7: program sequence with an erase-fail flag already set
        pulse_flags(3'b100);
        bus_write(0, 8'h40);
        check("R5 setup starts nothing", {31'd0, last_start}, 32'd0);
        bus_write(18'h1234, 8'h3C);
        check("R5 start pulse", {31'd0, last_start}, 32'd1);
        check("R5 start addr", {14'd0, last_addr}, 32'h1234);
        check("R5 start data", last_data, 32'h3C);
        wsm_busy = 1'b1;
        bus_read(18'h10, rd);
        check("R6 busy status", rd, 32'h20);
        bus_write(0, 8'hFF);
        bus_read(18'h10, rd);
        check("R6 FF ignored", rd, 32'h20);
        bus_write(0, 8'h50);
        bus_write(0, 8'h40);
        bus_write(0, 8'h00);
        check("R6 no restart", {31'd0, last_start}, 32'd0);
        bus_read(18'h10, rd);
        check("R6 clear ignored", rd, 32'h20);
        wsm_busy = 1'b0; wsm_done = 1'b1; wsm_prog_fail = 1'b1;
        @(posedge clk); @(negedge clk);
        wsm_done = 1'b0; wsm_prog_fail = 1'b0;
        bus_read(18'h10, rd);
        check("R7 done status", rd, 32'hB0);
        bus_read(18'h10, rd);
        check("R7 still status", rd, 32'hB0);
        bus_write(0, 8'hFF);
        bus_read(18'h10, rd);
        check("R7 array after FF", rd, 32'h4A);
        bus_write(0, 8'h50);

        // R9: snapshot on the later enable edge, frozen while held
        bus_write(0, 8'h70);
        ce_n = 1'b0;
        wsm_vpp_err = 1'b1;
        @(posedge clk); @(negedge clk);
        wsm_vpp_err = 1'b0; oe_n = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 snap at later edge", dout, 32'h88);
        wsm_prog_fail = 1'b1;
        @(posedge clk); @(negedge clk);
        wsm_prog_fail = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 frozen", dout, 32'h88);
        oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        oe_n = 1'b0;
        @(posedge clk); @(negedge clk);
        #1;
        check("R9 refreshed", dout, 32'h98);
        ce_n = 1'b1; oe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_write(0, 8'h50);

        // R10/R11: suspend and resume
        bus_write(0, 8'hFF);
        bus_write(0, 8'hB0);
        check("R10 no pulse when idle", {31'd0, last_susp}, 32'd0);
        bus_read(18'h10, rd);
        check("R10 status mode", rd, 32'h80);
        wsm_erasing = 1'b1;
        bus_write(0, 8'hB0);
        check("R10 suspend pulse", {31'd0, last_susp}, 32'd1);
        bus_read(18'h10, rd);
        check("R10 bit6 set", rd, 32'hC0);
        bus_write(0, 8'hB0);
        check("R10 no repeat", {31'd0, last_susp}, 32'd0);
        bus_write(0, 8'hD0);
        check("R11 resume pulse", {31'd0, last_res}, 32'd1);
        bus_read(18'h10, rd);
        check("R11 bit6 clear", rd, 32'h80);
        bus_write(0, 8'hFF);
        bus_write(0, 8'hD0);
        check("R11 no pulse", {31'd0, last_res}, 32'd0);
        bus_read(18'h10, rd);
        check("R11 mode unchanged", rd, 32'h4A);
        wsm_erasing = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule